// File: doc/BRIEF.md
# UART Baud Divisor Register Unit

This unit holds the baud-rate divisor of a UART and turns it into an oversampling tick. Software writes the divisor over a byte-wide register port. The divisor is split between a high-byte register and a low-byte register. A write to the high byte only stages its divisor bits. The staged bits and the new low byte then reach the active divisor together when the low byte is written. As a result, the tick generator never runs from a divisor that is half old and half new.

The tick generator stays idle after reset until transmit or receive has been enabled at least once. It also stays idle while the active divisor is zero. While it runs, it emits a one-cycle tick every `divisor` clock cycles. This rate is the 16x oversampling rate of the serial line.

The high-byte register also carries two interrupt-enable bits. One gates an external break-detect flag and the other gates an external input-edge flag. The gated flags are combined into one registered interrupt request.

Top module: `baud_div_regs`

## Requirements
- R1: After reset, reads of both registers return 0, `tick_o` is 0 and `irq_o` is 0.
- R2: A write with `wr_sel_i`=0 (high byte) does not change the active divisor. Reads of the high byte keep returning the active divisor bits in bits 4..0, and the low-byte read is unchanged.
- R3: A write with `wr_sel_i`=1 (low byte) loads the active divisor with {staged high bits, written byte} in the clock edge of the write. The staged high bits are bits 4..0 of the most recent high-byte write, or 0 if there has been none since reset.
- R4: Bit 5 of the high-byte read is always 0, whatever value was written to it.
- R5: No tick is emitted while neither `tx_en_i` nor `rx_en_i` has been sampled high since reset.
- R6: Once `tx_en_i` or `rx_en_i` has been sampled high, the generator stays enabled until reset, even when both enables go low again.
- R7: No tick is emitted while the active divisor is 0.
- R8: While running with divisor D, `tick_o` is a one-cycle pulse that repeats every D cycles. The first tick comes one cycle after running starts. A new divisor takes effect at the next counter reload.
- R9: `irq_o` equals (break flag AND bit 7 enable) OR (edge flag AND bit 6 enable), registered with one cycle of latency.
- R10: The enables in bits 7 and 6 of the high byte take effect at the high-byte write itself (no staging) and read back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 high byte, 1 low byte |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 high byte, 1 low byte |
| rd_data_o | output | 8 | Read data, combinational |
| tx_en_i | input | 1 | Transmit enable control |
| rx_en_i | input | 1 | Receive enable control |
| brk_flag_i | input | 1 | Break-detect flag |
| edge_flag_i | input | 1 | Input active-edge flag |
| tick_o | output | 1 | Oversampling tick pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench uses the default 13-bit divisor and byte width, so the 5-bit high field and the reserved bit 5 sit where software expects them. Small divisor values (1, 3, 4, 6) make full tick periods, a divisor change in mid-count and the one-tick-per-cycle case fit in a few hundred cycles. A large staged value of 0x1F00 checks that all five high bits travel through the staging buffer.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } reg_sel_e;

  localparam int unsigned BIT_BRK_IE  = 7;
  localparam int unsigned BIT_EDGE_IE = 6;
  localparam int unsigned BIT_RSVD    = 5;
  localparam int unsigned N_IRQ_SRC   = 2;
endpackage

// File: rtl/baud_div_regfile.sv
module baud_div_regfile
  import baud_div_pkg::*;
#(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              brk_ie_o,
  output logic              edge_ie_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]  stage_q;
  logic [DIV_W-1:0] div_q;
  logic             brk_ie_q, edge_ie_q;
  reg_sel_e         wsel, rsel;

  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  // high write: enables immediate, divisor bits staged only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      div_q     <= '0;
      brk_ie_q  <= 1'b0;
      edge_ie_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wsel == SEL_HI) begin
        stage_q   <= wr_data_i[HI_W-1:0];
        brk_ie_q  <= wr_data_i[BIT_BRK_IE];
        edge_ie_q <= wr_data_i[BIT_EDGE_IE];
      end else begin
        div_q <= {stage_q, wr_data_i};
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rsel == SEL_HI) begin
      rd_data_o[HI_W-1:0]    = div_q[DIV_W-1:BYTE_W];
      rd_data_o[BIT_BRK_IE]  = brk_ie_q;
      rd_data_o[BIT_EDGE_IE] = edge_ie_q;
    end else begin
      rd_data_o = div_q[BYTE_W-1:0];
    end
  end

  assign div_o     = div_q;
  assign brk_ie_o  = brk_ie_q;
  assign edge_ie_o = edge_ie_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             started_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             started_q, tick_q, run;

  assign run = started_q && (div_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else if (tx_en_i || rx_en_i) started_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_i - 1'b1;  // reload picks up any new divisor
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign started_o = started_q;
  assign tick_o    = tick_q;
endmodule

// File: rtl/baud_irq_gate.sv
module baud_irq_gate #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] gated;
  logic             irq_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign gated[g] = flag_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |gated;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_div_pkg::*;
#(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              brk_flag_i,
  input  logic              edge_flag_i,
  output logic              tick_o,
  output logic              irq_o
);
  logic [DIV_W-1:0] act_div;
  logic             brk_ie, edge_ie, started;

  baud_div_regfile #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .div_o     (act_div),
    .brk_ie_o  (brk_ie),
    .edge_ie_o (edge_ie)
  );

  baud_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .rx_en_i   (rx_en_i),
    .div_i     (act_div),
    .started_o (started),
    .tick_o    (tick_o)
  );

  baud_irq_gate #(.N_SRC(N_IRQ_SRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i ({edge_flag_i, brk_flag_i}),
    .en_i   ({edge_ie, brk_ie}),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/baud_div_chk.sv
module baud_div_chk #(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic              rd_sel_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              brk_flag_i,
  input logic              edge_flag_i,
  input logic              tick_o,
  input logic              irq_o,
  input logic [DIV_W-1:0]  act_div,
  input logic              started,
  input logic              brk_ie,
  input logic              edge_ie
);
  AST_HI_WR_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> $stable(act_div)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> !rd_data_o[5]); // R4
  AST_NO_TICK_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |=> !tick_o); // R5
  AST_START_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |=> started); // R6
  AST_NO_TICK_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div == '0) |=> !tick_o); // R7
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && act_div > 1 && $stable(act_div)) |=> !tick_o); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past((brk_flag_i & brk_ie) | (edge_flag_i & edge_ie))); // R9
endmodule

bind baud_div_regs baud_div_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .rd_sel_i    (rd_sel_i),
  .rd_data_o   (rd_data_o),
  .brk_flag_i  (brk_flag_i),
  .edge_flag_i (edge_flag_i),
  .tick_o      (tick_o),
  .irq_o       (irq_o),
  .act_div     (act_div),
  .started     (started),
  .brk_ie      (brk_ie),
  .edge_ie     (edge_ie)
);

// File: tb/baud_div_regs_tb_top.sv
`timescale 1ns/1ps
module baud_div_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_en = 1'b0, rx_en = 1'b0, brk = 1'b0, edg = 1'b0;
  logic       tick, irq;

  int n_chk = 0, n_fail = 0, tick_cnt = 0;
  bit done = 0;

  // reference model state
  int m_stage, m_div, m_cnt;
  bit m_bie, m_eie, m_started, m_tick, m_irq;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  baud_div_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .brk_flag_i(brk), .edge_flag_i(edg),
    .tick_o(tick), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stage = 0; m_div = 0; m_cnt = 0;
      m_bie = 0; m_eie = 0; m_started = 0; m_tick = 0; m_irq = 0;
    end else begin
      if (!(m_started && m_div != 0)) begin m_cnt = 0; m_tick = 0; end
      else if (m_cnt == 0) begin m_cnt = m_div - 1; m_tick = 1; end
      else begin m_cnt = m_cnt - 1; m_tick = 0; end
      m_irq = (brk && m_bie) || (edg && m_eie);
      if (tx_en || rx_en) m_started = 1;
      if (wr_en) begin
        if (!wr_sel) begin
          m_stage = wr_data % 32; m_bie = wr_data[7]; m_eie = wr_data[6];
        end else m_div = m_stage * 256 + wr_data;
      end
    end
  end

  function automatic int model_rd(bit sel);
    if (!sel) return (m_bie ? 128 : 0) + (m_eie ? 64 : 0) + m_div / 256;
    return m_div % 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_ni) begin
      chk("R8", int'(tick), int'(m_tick));
      chk("R9", int'(irq), int'(m_irq));
      chk("R3", int'(rd_data), model_rd(rd_sel));
      if (tick) tick_cnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, int d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(bit sel, output int v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = int'(rd_data);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    cyc(3);
    rst_ni = 1;
    cmp_on = 1;
    // R1 reset state
    rd(0, v); chk("R1", v, 0);
    rd(1, v); chk("R1", v, 0);
    chk("R1", int'(tick), 0);
    chk("R1", int'(irq), 0);

    // R5 divisor 4 loaded, no enable yet
    wr(0, 8'h00); wr(1, 8'h04);
    tick_cnt = 0; cyc(40);
    chk("R5", tick_cnt, 0);

    // R6 one-cycle tx enable, then both low
    @(negedge clk); tx_en = 1; @(negedge clk); tx_en = 0;
    cyc(2);
    tick_cnt = 0; cyc(40);
    chk("R6", tick_cnt, 10);

    // R2 R4 R10 high write staged, enables immediate
    wr(0, 8'hFF);
    rd(0, v); chk("R4", v & 8'h20, 0);
    chk("R10", v, 8'hC0);
    chk("R2", v & 8'h1F, 0);
    rd(1, v); chk("R2", v, 4);
    tick_cnt = 0; cyc(20);
    chk("R2", tick_cnt, 5);

    // R3 low write merges staged high bits
    wr(1, 8'h00);
    rd(0, v); chk("R3", v & 8'h1F, 8'h1F);
    rd(1, v); chk("R3", v, 0);

    // R7 divisor zero stops ticks
    wr(0, 8'hC0); wr(1, 8'h00);
    tick_cnt = 0; cyc(30);
    chk("R7", tick_cnt, 0);

    // R9 irq gating
    @(negedge clk); brk = 1; cyc(2);
    chk("R9", int'(irq), 1);
    brk = 0;
    wr(0, 8'h40);
    @(negedge clk); brk = 1; cyc(2);
    chk("R9", int'(irq), 0);
    brk = 0; edg = 1; cyc(2);
    chk("R9", int'(irq), 1);
    edg = 0; cyc(2);
    chk("R9", int'(irq), 0);

    // R8 divisor 1 ticks every cycle
    wr(0, 8'h00); wr(1, 8'h01);
    cyc(2);
    tick_cnt = 0; cyc(16);
    chk("R8", tick_cnt, 16);

    // R8 divisor 3 then 6 mid-count, with rx enable toggling
    wr(1, 8'h03);
    @(negedge clk); rx_en = 1; cyc(5); rx_en = 0;
    wr(1, 8'h06);
    cyc(30);

    // R3 low write with no new high write reuses last staged bits
    wr(0, 8'h02); wr(1, 8'h10);
    rd(0, v); chk("R3", v, 8'h02);
    rd(1, v); chk("R3", v, 8'h10);
    wr(1, 8'h11);
    rd(0, v); chk("R3", v, 8'h02);
    cyc(5);
    finish_run();
  end
endmodule